// File: doc/BRIEF.md
# Phase-Accumulator Rate Generator

This block is a numerically controlled oscillator that runs entirely on one fast system clock. A 32-bit phase register advances by a programmable tuning word on every cycle. Two outputs come from this phase:

- a square wave, taken from the most significant phase bit;
- a single-cycle rate tick, taken from the carry out of the addition.

Both outputs come straight from flip-flops clocked by the system clock, so no combinational glitch reaches them.

The output frequency is `Fsys * word / 2^32`. The tick is meant as a clock enable. Logic that must run at the programmed rate can then stay in the system-clock domain instead of being clocked by a derived signal. When the rate does not divide the system clock exactly, the edges of both outputs move by up to one system-clock period from their ideal positions.

A new word is captured into a shadow register when the load strobe is high. The phase keeps running across a load and is never cleared by it. A word of zero stops the oscillator where it stands.

Top module: `rate_gen`

## Requirements
- R1: A synchronous active-high reset clears the phase, the tuning word, `wave_out` and `rate_tick` to zero. After reset, both outputs stay low until a word is loaded.
- R2: While the applied tuning word is zero, the phase does not change, `rate_tick` stays low and `wave_out` keeps its level.
- R3: A word presented with `tune_load` high at a clock edge is captured at that edge. It is first added at the following edge; the addition at the capture edge still uses the previous word.
- R4: Loading a word does not reset the phase. Accumulation continues from the current phase value.
- R5: Starting from phase zero, the number of `rate_tick` pulses over N cycles equals floor(N * word / 2^32) within one. For words below 2^31, the number of rising edges of `wave_out` matches the tick count within one.
- R6: `wave_out` equals bit 31 of the phase register. For words below 2^31, every `rate_tick` pulse coincides with a falling edge of `wave_out`.
- R7: `rate_tick` is bit 32 of the 33-bit sum of phase and word, registered. It is high for exactly one cycle per phase wrap. With words below 2^31 it is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 32 | Tuning word to capture |
| tune_load | input | 1 | Capture strobe for `tune_word` |
| wave_out | output | 1 | Registered square wave (phase MSB) |
| rate_tick | output | 1 | Registered one-cycle enable at each phase wrap |

## Verification
A wrong phase or a wrong shadow word shows up at the ports in two ways:

- **As a rate error.** The tick count over a window drifts away from floor(N * word / 2^32). For coarse words this is visible within a few hundred cycles.
- **As a timing error.** A wrap happens one cycle early or late, for example when a load is applied at the wrong edge or clears the phase. The directed continuity sequence catches this on the exact cycle: it expects a tick two edges after a reload and a particular wave level in between.

A stuck-at-zero word stops every tick at once, and so does a phase register that fails to update.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int unsigned RG_PHASE_W_DEF = 32;

    typedef struct packed {
        logic wave;
        logic tick;
    } rg_out_t;

    function automatic rg_out_t rg_split(input logic msb, input logic carry);
        rg_out_t o;
        o.wave = msb;
        o.tick = carry;
        return o;
    endfunction

endpackage

// File: rtl/rg_tune_shadow.sv
module rg_tune_shadow #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
        end
    end
endmodule

// File: rtl/rg_phase_accum.sv
module rg_phase_accum #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tune,
    output logic [W-1:0] phase_q,
    output logic [W:0]   sum
);
    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, tune};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= sum[W-1:0];
        end
    end
endmodule

// File: rtl/rg_out_retime.sv
module rg_out_retime
    import rg_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [W:0] sum,
    output rg_out_t    out_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= rg_split(sum[W-1], sum[W]);
        end
    end
endmodule

// File: rtl/rate_gen.sv
module rate_gen
    import rg_pkg::*;
#(
    parameter int unsigned PHASE_W = RG_PHASE_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic               tune_load,
    output logic               wave_out,
    output logic               rate_tick
);
    logic [PHASE_W-1:0] tune_q;
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W:0]   sum;
    rg_out_t            out_q;

    rg_tune_shadow #(.W(PHASE_W)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .load    (tune_load),
        .word_in (tune_word),
        .word_q  (tune_q)
    );

    rg_phase_accum #(.W(PHASE_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .tune    (tune_q),
        .phase_q (phase_q),
        .sum     (sum)
    );

    rg_out_retime #(.W(PHASE_W)) u_retime (
        .clk   (clk),
        .rst   (rst),
        .sum   (sum),
        .out_q (out_q)
    );

    assign wave_out  = out_q.wave;
    assign rate_tick = out_q.tick;
endmodule

// File: rtl/rate_gen_chk.sv
module rate_gen_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] tune_word,
    input logic         tune_load,
    input logic [W-1:0] tune_q,
    input logic [W-1:0] phase_q,
    input logic         wave,
    input logic         tick
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!wave && !tick && phase_q == '0 && tune_q == '0));

    // R2
    a_r2_zero_word_holds: assert property (@(posedge clk) disable iff (rst)
        ($past(tune_q) == '0 && !$past(rst)) |-> ($stable(phase_q) && !tick));

    // R3
    a_r3_load_captures: assert property (@(posedge clk) disable iff (rst)
        tune_load |=> (tune_q == $past(tune_word)));

    // R6
    a_r6_wave_is_msb: assert property (@(posedge clk) disable iff (rst)
        wave == phase_q[W-1]);

    // R6
    a_r6_tick_on_fall: assert property (@(posedge clk) disable iff (rst)
        (tick && !$past(rst) && $past(tune_q) < HALF) |-> ($past(wave) && !wave));

    // R7
    a_r7_no_double_tick: assert property (@(posedge clk) disable iff (rst)
        (tick && !$past(rst) && !$past(rst, 2) && $past(tune_q) < HALF && $past(tune_q, 2) < HALF)
            |-> !$past(tick));
endmodule

bind rate_gen rate_gen_chk #(.W(PHASE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tune_word (tune_word),
    .tune_load (tune_load),
    .tune_q    (tune_q),
    .phase_q   (phase_q),
    .wave      (wave_out),
    .tick      (rate_tick)
);

// File: tb/tb_rate_gen.sv
module tb_rate_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tune_word = '0;
    logic        tune_load = 1'b0;
    logic        wave_out;
    logic        rate_tick;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rate_gen dut (
        .clk       (clk),
        .rst       (rst),
        .tune_word (tune_word),
        .tune_load (tune_load),
        .wave_out  (wave_out),
        .rate_tick (rate_tick)
    );

    localparam int NVEC = 7;
    localparam logic [31:0] VEC_WORD [NVEC] = '{
        32'h8000_0000, 32'h4000_0000, 32'h1000_0000, 32'h0147_AE14,
        32'h0000_0001, 32'hFFFF_FFFF, 32'h5555_5555
    };
    localparam int VEC_LEN [NVEC] = '{1000, 1000, 1000, 1500, 1000, 1000, 999};

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [31:0] w);
        tune_word = w;
        tune_load = 1'b1;
        step();
        tune_load = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ticks;
        int changes;
        int rises;
        logic prev;
        longint exp_t;

        @(negedge clk);
        repeat (4) step();
        // R1: reset state
        check(!wave_out && !rate_tick, "R1 reset outputs", {wave_out, rate_tick}, 0);
        rst = 1'b0;

        // R1/R2: idle with zero word after reset
        ticks = 0; changes = 0; prev = wave_out;
        for (int i = 0; i < 50; i++) begin
            step();
            ticks += rate_tick;
            if (wave_out != prev) changes++;
            prev = wave_out;
        end
        check(ticks == 0 && changes == 0, "R1 idle after reset", ticks + changes, 0);

        // R3/R4: continuity across reload
        load_word(32'h4000_0000);                 // phase 0 (old word 0)
        step();                                   // phase 2^30
        step();                                   // phase 2^31
        check(wave_out == 1'b1, "R6 wave msb", wave_out, 1);
        load_word(32'h8000_0000);                 // old word used: 3*2^30
        check(wave_out == 1'b1 && !rate_tick, "R3 old word at load edge", {wave_out, rate_tick}, 2);
        step();                                   // 5*2^30 -> 2^30, carry
        check(rate_tick == 1'b1 && wave_out == 1'b0, "R4 phase kept across load", {wave_out, rate_tick}, 1);
        step();                                   // 3*2^30
        check(rate_tick == 1'b0 && wave_out == 1'b1, "R7 tick one cycle", {wave_out, rate_tick}, 2);

        // R2: zero word freezes mid-run
        load_word(32'h0000_0000);                 // old 2^31 used: 5*2^30 -> 2^30, tick
        check(rate_tick == 1'b1 && wave_out == 1'b0, "R3 last step before freeze", {wave_out, rate_tick}, 1);
        ticks = 0; changes = 0; prev = wave_out;
        for (int i = 0; i < 40; i++) begin
            step();
            ticks += rate_tick;
            if (wave_out != prev) changes++;
            prev = wave_out;
        end
        check(ticks == 0 && changes == 0 && wave_out == 1'b0, "R2 frozen", ticks + changes, 0);

        // R3: word from freeze takes effect one edge after capture
        load_word(32'h8000_0000);                 // word 0 still applied
        check(wave_out == 1'b0 && !rate_tick, "R3 no effect at capture edge", {wave_out, rate_tick}, 0);
        step();                                   // 2^30 + 2^31
        check(wave_out == 1'b1, "R3 effect next edge", wave_out, 1);

        // R1: mid-run reset
        rst = 1'b1;
        step();
        check(!wave_out && !rate_tick, "R1 mid-run reset", {wave_out, rate_tick}, 0);
        rst = 1'b0;
        ticks = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            ticks += rate_tick;
        end
        check(ticks == 0 && !wave_out, "R1 word cleared", ticks, 0);

        // R5: rate table
        for (int v = 0; v < NVEC; v++) begin
            rst = 1'b1;
            step();
            rst = 1'b0;
            load_word(VEC_WORD[v]);
            ticks = 0; rises = 0; prev = wave_out;
            for (int i = 0; i < VEC_LEN[v]; i++) begin
                step();
                ticks += rate_tick;
                if (wave_out && !prev) rises++;
                prev = wave_out;
            end
            exp_t = (longint'(VEC_LEN[v]) * longint'(VEC_WORD[v])) >>> 32;
            check((ticks >= exp_t - 1) && (ticks <= exp_t + 1), "R5 tick count", ticks, exp_t);
            if (VEC_WORD[v] < 32'h8000_0000) begin
                check((rises >= ticks - 1) && (rises <= ticks + 1), "R5 wave rises", rises, ticks);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule